// File: doc/BRIEF.md
# Concatenation-Incrementation Carry Skip Adder

This block is a purely combinational N-bit binary adder (32 bits by default) for datapaths that want a carry skip structure with short skip cells. The operand width is split into a chain of stages whose widths come from a parameter list. The lowest stage is an ordinary ripple block that takes the external carry-in. Every higher stage adds its operand slice with a carry-in of zero, so its lowest cell is a half adder. An increment block then folds in the carry that actually arrives at that stage.

The carry passes from stage to stage through skip cells instead of multiplexers. A skip cell sends the stage's incoming carry straight on when every bit of the stage propagates. Otherwise it passes on the zero-carry ripple carry of that stage. The cells alternate between AND-OR-invert and OR-AND-invert forms, so the polarity of the chained carry flips at every stage. Each consumer undoes the inversion locally, and the final carry-out is always delivered in true polarity. An elaboration check rejects a size list that does not add up to the operand width.

Top module: `csa_adder`

## Requirements
- R1: For any operands, {cout, sum} equals opa + opb + cin taken as an unsigned (N+1)-bit value.
- R2: When opa XOR opb is all ones, cout equals cin, and sum is all ones for cin=0 and all zeros for cin=1.
- R3: When opa is all ones and opb is zero with cin=1, or opa is all ones and opb is one with cin=0, sum is all zeros and cout is 1.
- R4: When both operands are zero, sum is zero except bit 0, which equals cin, and cout is 0.
- R5: A carry generated at the top bit of any stage and propagated through all higher bits yields zero in those higher sum bits and cout=1. The internal chained carry after stage k (k counted from 0 at the least significant end) equals the true carry out of bit positions 0 through the top of stage k, inverted when k is even.
- R6: cout is in true polarity both for an even stage count (default 10 stages over 32 bits) and for an odd stage count (9 stages over 16 bits).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand, unsigned |
| opb | input | N | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of the total |
| cout | output | 1 | Carry out of bit N-1, true polarity |

## Verification
Every result is due in the same clock cycle as its stimulus, since no register lies between the operand ports and sum or cout. The driver applies a vector on a rising edge and queues its expected total. The monitor compares on the following falling edge, after the combinational paths have settled and before the next vector arrives. The bench computes expected values with a plain behavioural addition. Directed vectors walk a generated carry through every stage boundary, and a second instance with an odd stage count checks the carry-out polarity.

// File: rtl/csa_pkg.sv
// Package: shared definitions for the carry skip adder.
// Assumes: stage indices count from 0 at the least significant end.
package csa_pkg;

    // Form of the inverting skip cell used by a stage.
    typedef enum logic {
        SKIP_AOI = 1'b0,   // incoming carry is true, outgoing is inverted
        SKIP_OAI = 1'b1    // incoming carry is inverted, outgoing is true
    } skip_kind_e;

    // Skip cell form for stage idx: the forms alternate, starting with AOI.
    function automatic skip_kind_e kind_of_stage(input int idx);
        return (idx % 2 == 0) ? SKIP_AOI : SKIP_OAI;
    endfunction

    // True when the carry leaving stage idx is carried in inverted form.
    function automatic bit out_inverted(input int idx);
        return (idx % 2 == 0);
    endfunction

endpackage

// File: rtl/csa_ripple.sv
// Module: ripple block of one stage.
// Adds two W-bit slices. With USE_CIN=0 the carry input is ignored and the
// lowest cell is a half adder (zero carry). Also gives the AND of all the
// propagate bits of the slice, which serves as the stage's skip select.
// Assumes W >= 1.
module csa_ripple #(
    parameter int W       = 4,
    parameter bit USE_CIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic [W-1:0] p,
    output logic         co,
    output logic         p_all
);

    logic [W:0] c;

    // Per-bit propagate signals.
    assign p = a ^ b;

    generate
        if (USE_CIN) begin : g_fa0
            assign c[0] = ci;
        end else begin : g_ha0
            assign c[0] = 1'b0;
        end
    endgenerate

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_cell
            if (i == 0 && !USE_CIN) begin : g_half
                // Half adder cell: no carry input.
                assign s[i]   = p[i];
                assign c[i+1] = a[i] & b[i];
            end else begin : g_full
                // Full adder cell.
                assign s[i]   = p[i] ^ c[i];
                assign c[i+1] = (a[i] & b[i]) | (p[i] & c[i]);
            end
        end
    endgenerate

    assign co    = c[W];
    assign p_all = &p;

endmodule

// File: rtl/csa_incr.sv
// Module: increment block of one stage.
// Adds a single carry bit to a zero-carry partial sum using an AND chain
// over the propagate bits and one XOR per bit. The carry out of this block
// is not needed: the skip cell supplies the stage carry.
// Assumes W >= 1.
module csa_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] part,
    input  logic [W-1:0] p,
    input  logic         ci,
    output logic [W-1:0] s
);

    logic [W:0] run;

    assign run[0] = ci;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // The carry passes bit i only while every lower propagate bit is set.
            assign run[i+1] = run[i] & p[i];
            assign s[i]     = part[i] ^ run[i];
        end
    endgenerate

endmodule

// File: rtl/csa_skip.sv
// Module: inverting skip cell.
// Next carry = ripple carry OR (stage propagate AND incoming carry).
// This holds because a zero-carry ripple block cannot produce a carry when
// all of its bits propagate.
// AOI form: takes a true carry and gives an inverted one.
// OAI form: takes an inverted carry and gives a true one.
module csa_skip
    import csa_pkg::*;
#(
    parameter skip_kind_e KIND = SKIP_AOI
) (
    input  logic prop,
    input  logic ci_w,
    input  logic rc,
    output logic co_w
);

    generate
        if (KIND == SKIP_AOI) begin : g_aoi
            // ci_w is true, co_w is inverted.
            assign co_w = ~(rc | (prop & ci_w));
        end else begin : g_oai
            // ci_w is inverted, co_w is true.
            assign co_w = ~((~rc) & ((~prop) | ci_w));
        end
    endgenerate

endmodule

// File: rtl/csa_stage.sv
// Module: one adder stage (ripple block, optional incrementer, skip cell).
// IDX selects the first-stage form (external carry into the ripple block)
// and the skip cell form. The incoming carry wire has the polarity left by
// the previous stage. It is restored locally for the incrementer.
module csa_stage
    import csa_pkg::*;
#(
    parameter int W   = 4,
    parameter int IDX = 0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci_w,
    output logic [W-1:0] s,
    output logic         co_w
);

    localparam skip_kind_e KIND  = kind_of_stage(IDX);
    localparam bit         FIRST = (IDX == 0);

    logic         ci_true;
    logic [W-1:0] part;
    logic [W-1:0] p;
    logic         rc;
    logic         p_all;

    // Undo the chain inversion for stages that take an inverted carry.
    assign ci_true = (KIND == SKIP_OAI) ? ~ci_w : ci_w;

    csa_ripple #(
        .W       (W),
        .USE_CIN (FIRST)
    ) u_ripple (
        .a     (a),
        .b     (b),
        .ci    (ci_true),
        .s     (part),
        .p     (p),
        .co    (rc),
        .p_all (p_all)
    );

    generate
        if (FIRST) begin : g_first
            // The ripple block already includes the carry.
            assign s = part;
        end else begin : g_inc
            csa_incr #(.W(W)) u_incr (
                .part (part),
                .p    (p),
                .ci   (ci_true),
                .s    (s)
            );
        end
    endgenerate

    csa_skip #(.KIND(KIND)) u_skip (
        .prop (p_all),
        .ci_w (ci_w),
        .rc   (rc),
        .co_w (co_w)
    );

endmodule

// File: rtl/csa_adder.sv
// Module: top of the concatenation-incrementation carry skip adder.
// Purely combinational. STAGE_W lists the stage widths from the least
// significant end. Their total must equal N, which is checked at
// elaboration. stage_carry[k+1] is the carry leaving stage k, in the
// polarity its skip cell gives.
module csa_adder
    import csa_pkg::*;
#(
    parameter int N       = 32,
    parameter int STAGE_Q = 10,
    parameter int STAGE_W [STAGE_Q] = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1}
) (
    input  logic [N-1:0] opa,
    input  logic [N-1:0] opb,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);

    // Lowest bit position of stage idx.
    function automatic int stage_lo(input int idx);
        int acc;
        acc = 0;
        for (int i = 0; i < idx; i++) acc += STAGE_W[i];
        return acc;
    endfunction

    localparam int TOTAL_W = stage_lo(STAGE_Q);

    generate
        if (TOTAL_W != N) begin : g_bad_sizes
            $error("csa_adder: stage widths do not add up to N");
        end
    endgenerate

    logic [STAGE_Q:0] stage_carry;

    assign stage_carry[0] = cin;

    genvar k;
    generate
        for (k = 0; k < STAGE_Q; k++) begin : g_stage
            localparam int LO = stage_lo(k);
            localparam int W  = STAGE_W[k];

            csa_stage #(
                .W   (W),
                .IDX (k)
            ) u_stage (
                .a    (opa[LO +: W]),
                .b    (opb[LO +: W]),
                .ci_w (stage_carry[k]),
                .s    (sum[LO +: W]),
                .co_w (stage_carry[k+1])
            );
        end
    endgenerate

    // Deliver the final carry in true polarity whatever the stage count.
    generate
        if (out_inverted(STAGE_Q - 1)) begin : g_cout_fix
            assign cout = ~stage_carry[STAGE_Q];
        end else begin : g_cout_pass
            assign cout = stage_carry[STAGE_Q];
        end
    endgenerate

endmodule

// File: rtl/csa_adder_chk.sv
// Module: assertion checker for csa_adder, attached with bind.
// Compares the ports and the chained stage carries with a bit-serial model.
// Checks are skipped while any input is unknown.
module csa_adder_chk #(
    parameter int N       = 32,
    parameter int STAGE_Q = 10,
    parameter int STAGE_W [STAGE_Q] = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1}
) (
    input logic [N-1:0]       opa,
    input logic [N-1:0]       opb,
    input logic               cin,
    input logic [N-1:0]       sum,
    input logic               cout,
    input logic [STAGE_Q:0]   stage_carry
);

    logic [N:0] total;

    assign total = {1'b0, opa} + {1'b0, opb} + {{N{1'b0}}, cin};

    // Whole-result checks.
    always_comb begin
        if (!$isunknown({opa, opb, cin})) begin
            assert_total_R1: assert ({cout, sum} == total)
                else $error("R1 total mismatch");
            if (&(opa ^ opb)) begin
                assert_all_prop_R2: assert (cout == cin && sum == {N{~cin}})
                    else $error("R2 all-propagate mismatch");
            end
            if (&opa && ((opb == '0 && cin) || (opb == N'(1) && !cin))) begin
                assert_wrap_R3: assert (cout && sum == '0)
                    else $error("R3 wrap mismatch");
            end
            if (opa == '0 && opb == '0) begin
                assert_zero_R4: assert (!cout && sum == {{(N-1){1'b0}}, cin})
                    else $error("R4 zero-operand mismatch");
            end
        end
    end

    // Chained stage carries against a ripple model (R5).
    always_comb begin
        automatic logic c   = cin;
        automatic int   pos = 0;
        if (!$isunknown({opa, opb, cin})) begin
            for (int k = 0; k < STAGE_Q; k++) begin
                for (int i = 0; i < STAGE_W[k]; i++) begin
                    c = (opa[pos] & opb[pos]) | ((opa[pos] ^ opb[pos]) & c);
                    pos++;
                end
                assert_stage_carry_R5: assert (stage_carry[k+1] == (c ^ (k % 2 == 0)))
                    else $error("R5 stage carry polarity mismatch");
            end
        end
    end

endmodule

bind csa_adder csa_adder_chk #(
    .N       (N),
    .STAGE_Q (STAGE_Q),
    .STAGE_W (STAGE_W)
) u_chk (
    .opa         (opa),
    .opb         (opb),
    .cin         (cin),
    .sum         (sum),
    .cout        (cout),
    .stage_carry (stage_carry)
);

// File: tb/csa_adder_bench.sv
// Bench: scoreboard for two adder instances (even and odd stage count).
// The driver applies vectors on rising edges and queues expected totals.
// The monitor compares on falling edges.
module csa_adder_bench;

    localparam int NW = 32;
    localparam int QW = 10;
    localparam int NS = 16;
    localparam int QS = 9;
    localparam int SIZES_W [QW] = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1};
    localparam int SIZES_S [QS] = '{1, 2, 2, 3, 3, 2, 1, 1, 1};

    typedef struct {
        logic [NW:0] exp_w;
        logic [NS:0] exp_s;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] a_w = '0, b_w = '0;
    logic [NS-1:0] a_s = '0, b_s = '0;
    logic          ci = 1'b0;
    logic [NW-1:0] sum_w;
    logic [NS-1:0] sum_s;
    logic          cout_w, cout_s;

    item_t q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    csa_adder u_csa_adder (
        .opa (a_w), .opb (b_w), .cin (ci), .sum (sum_w), .cout (cout_w)
    );

    csa_adder #(
        .N (NS), .STAGE_Q (QS), .STAGE_W (SIZES_S)
    ) u_csa_adder_odd (
        .opa (a_s), .opb (b_s), .cin (ci), .sum (sum_s), .cout (cout_s)
    );

    // Driver: apply one vector to both instances and queue expected totals.
    task automatic drive(input logic [NW-1:0] a, input logic [NW-1:0] b,
                         input logic c, input string tag);
        item_t it;
        @(posedge clk);
        a_w <= a; b_w <= b;
        a_s <= a[NS-1:0]; b_s <= b[NS-1:0];
        ci  <= c;
        it.exp_w = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, c};
        it.exp_s = {1'b0, a[NS-1:0]} + {1'b0, b[NS-1:0]} + {{NS{1'b0}}, c};
        it.tag   = tag;
        q.push_back(it);
    endtask

    // Monitor: compare settled outputs with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_tests++;
            if ({cout_w, sum_w} !== it.exp_w) begin
                n_fail++;
                $display("FAIL %s wide: got %h expected %h", it.tag, {cout_w, sum_w}, it.exp_w);
            end
            n_tests++;
            if ({cout_s, sum_s} !== it.exp_s) begin
                n_fail++;
                $display("FAIL %s odd-stage (R6): got %h expected %h", it.tag, {cout_s, sum_s}, it.exp_s);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        int lo;
        int hi;
        logic [NW-1:0] ones;
        ones = '1;
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        // Reset state: zero operands give zero outputs (R4).
        drive('0, '0, 1'b0, "R4 reset zero");
        drive('0, '0, 1'b1, "R4 zero with cin");
        // All-propagate patterns (R2).
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R2 propagate cin0");
        drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R2 propagate cin1");
        drive(ones, '0, 1'b0, "R2 ones plus zero");
        // All ones plus one (R3).
        drive(ones, '0, 1'b1, "R3 ones plus cin");
        drive(ones, 32'd1, 1'b0, "R3 ones plus one");
        drive(ones, ones, 1'b1, "R1 ones plus ones plus cin");
        // Walk a generated carry from each stage top through the rest (R5).
        lo = 0;
        for (int k = 0; k < QW; k++) begin
            logic [NW-1:0] a;
            logic [NW-1:0] b;
            hi = lo + SIZES_W[k] - 1;
            a = ones << hi;
            b = '0;
            b[hi] = 1'b1;
            drive(a, b, 1'b0, "R5 walking stage carry");
            lo = hi + 1;
        end
        // Same walk on the odd-stage instance's width (R6).
        lo = 0;
        for (int k = 0; k < QS; k++) begin
            logic [NW-1:0] a;
            logic [NW-1:0] b;
            hi = lo + SIZES_S[k] - 1;
            a = {{(NW-NS){1'b0}}, {NS{1'b1}} << hi};
            b = '0;
            b[hi] = 1'b1;
            drive(a, b, 1'b1, "R6 odd-stage carry walk");
            lo = hi + 1;
        end
        // Random operands (R1).
        for (int i = 0; i < 3000; i++) begin
            drive($urandom, $urandom, 1'($urandom), "R1 random");
        end
        @(posedge clk);
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule